// File: doc/BRIEF.md
# Paged Address Translator with Recency-Ordered Lookaside Buffer

This block turns a processor's virtual address into a real memory address, using fixed pages of 2^OFS_W words. The low OFS_W bits of the address go straight through as the offset inside the page. The bits above them form the page number. That page number is compared in parallel against every slot of a small fully associative lookaside buffer. On a hit, the stored frame base is joined to the offset in the same cycle, and no table access is made.

On a miss, the block stalls the requester. It issues one read of the page-table entry through a simple request/response port, then installs the returned entry. The entry goes into an empty slot if one exists, otherwise into the least recently used slot. On the cycle after the response, the held request is retried and completes as a hit. Each entry carries a defined flag, a frame base and a two-bit permission code. An entry that is not defined is never installed, and the held request completes with an addressing fault. An access type that the permission code does not allow completes with a protection fault. A flush input empties the buffer, for use on a context switch.

Back-pressure rules: the request side is valid/ready. While `req_valid` is high and `req_ready` is low, the requester must hold `req_vaddr` and `req_write` stable. The result has no ready. `xl_valid` is high exactly in the cycle a request is accepted (`req_valid && req_ready`), and the result is valid only in that cycle.

Top module: `vm_xlate`

## Requirements
- R1: A result without a fault carries `xl_paddr` = {frame base, `req_vaddr[OFS_W-1:0]`}; the page number is `req_vaddr[VA_W-1:OFS_W]`.
- R2: A request whose page is in the buffer is accepted in its first cycle (`req_ready` high) and makes no table read.
- R3: A request whose page is absent sees `req_ready` low and makes exactly one single-cycle `pt_rd_en` pulse with `pt_rd_vpn` equal to its page number. It is accepted in the cycle after the cycle in which `pt_rsp_valid` is high.
- R4: A defined table entry is installed, so a later access to that page hits.
- R5: A table entry with `pt_rsp_defined` = 0 completes the held request with `xl_fault_undef` = 1 and `xl_paddr` = 0. The entry is not installed, so the next access to that page misses again.
- R6: Permission bit 0 allows reads and bit 1 allows writes (`req_write` = 1). A disallowed access completes with `xl_fault_prot` = 1 and `xl_paddr` = 0, and the entry stays in the buffer.
- R7: When the buffer is full, a refill replaces the entry whose last use is oldest. Every hit counts as a use, including a hit that faults on protection, and so does an install.
- R8: A cycle with `flush` high invalidates every buffered entry, so each page misses on its next access.
- R9: `xl_valid` is high only when `req_valid` is high, and at most one fault flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | Access type: 1 write, 0 read |
| xl_valid | output | 1 | Result present (accept cycle) |
| xl_paddr | output | PA_W | Real address, 0 on any fault |
| xl_fault_undef | output | 1 | Addressing fault: page not defined |
| xl_fault_prot | output | 1 | Protection fault: access type denied |
| pt_rd_en | output | 1 | One-cycle table read request |
| pt_rd_vpn | output | VA_W-OFS_W | Page number to read |
| pt_rsp_valid | input | 1 | Table response present |
| pt_rsp_defined | input | 1 | Entry is defined |
| pt_rsp_frame | input | PA_W-OFS_W | Frame base of the entry |
| pt_rsp_prot | input | 2 | Permission code, bit 0 read, bit 1 write |

## Verification
The bench sweeps every page number with both access types against a computed page table. It keeps its own recency list, so it can predict each hit and miss. A wrong victim choice shows up as an extra or a missing table read on a later revisit. A buffer that forgot to refresh on a protection-faulting hit would evict the wrong page. Undefined pages are visited twice: a design that installed them would hit the second time and report no fault. Access timing is tied to the table response cycle. A flush is followed by a revisit of a buffered page, which must miss again.

// File: rtl/vm_xlate_pkg.sv
package vm_xlate_pkg;
  typedef enum logic [1:0] {
    ST_LOOK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_UNDEF = 2'd2
  } xl_state_e;

  localparam int PERM_W  = 2;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
endpackage

// File: rtl/vm_xlate_cam.sv
module vm_xlate_cam #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int FRM_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [VPN_W-1:0]                 look_vpn,
  output logic                             hit,
  output logic [IDX_W-1:0]                 hit_idx,
  output logic [FRM_W-1:0]                 hit_frame,
  output logic [vm_xlate_pkg::PERM_W-1:0]  hit_perm,
  output logic                             has_free,
  output logic [IDX_W-1:0]                 free_idx,
  input  logic                             ins_en,
  input  logic [IDX_W-1:0]                 ins_idx,
  input  logic [VPN_W-1:0]                 ins_vpn,
  input  logic [FRM_W-1:0]                 ins_frame,
  input  logic [vm_xlate_pkg::PERM_W-1:0]  ins_perm
);
  import vm_xlate_pkg::*;

  logic [ENTRIES-1:0]     slot_ok;
  logic [VPN_W-1:0]       slot_vpn   [ENTRIES];
  logic [FRM_W-1:0]       slot_frame [ENTRIES];
  logic [PERM_W-1:0]      slot_perm  [ENTRIES];
  logic [ENTRIES-1:0]     match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    // Install writes its own slot after a flush in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_ok[g]    <= 1'b0;
        slot_vpn[g]   <= '0;
        slot_frame[g] <= '0;
        slot_perm[g]  <= '0;
      end else begin
        if (flush) slot_ok[g] <= 1'b0;
        if (ins_en && ins_idx == IDX_W'(g)) begin
          slot_ok[g]    <= 1'b1;
          slot_vpn[g]   <= ins_vpn;
          slot_frame[g] <= ins_frame;
          slot_perm[g]  <= ins_perm;
        end
      end
    end
    assign match[g] = slot_ok[g] && (slot_vpn[g] == look_vpn);
  end

  always_comb begin
    hit       = |match;
    hit_idx   = '0;
    hit_frame = '0;
    hit_perm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_idx   = hit_idx   | IDX_W'(i);
        hit_frame = hit_frame | slot_frame[i];
        hit_perm  = hit_perm  | slot_perm[i];
      end
    end
  end

  always_comb begin
    has_free = ~&slot_ok;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_ok[i]) free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vm_xlate_lru.sv
module vm_xlate_lru #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_en,
  input  logic [IDX_W-1:0] use_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  // Ages form a permutation of 0..ENTRIES-1; 0 is most recent.
  logic [IDX_W-1:0] age [ENTRIES];
  logic [IDX_W-1:0] used_age;

  always_comb begin
    used_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (use_idx == IDX_W'(i)) used_age = age[i];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age[g] <= IDX_W'(g);
      end else if (use_en) begin
        if (use_idx == IDX_W'(g))  age[g] <= '0;
        else if (age[g] < used_age) age[g] <= age[g] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vm_xlate_ctrl.sv
module vm_xlate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic perm_ok,
  input  logic rsp_valid,
  input  logic rsp_defined,
  output logic ready,
  output logic accept,
  output logic grant,
  output logic fault_undef,
  output logic fault_prot,
  output logic rd_en,
  output logic ins_en
);
  import vm_xlate_pkg::*;

  xl_state_e st_q, st_d;

  always_comb begin
    ready       = (st_q == ST_LOOK && hit) || (st_q == ST_UNDEF);
    accept      = req_valid && ready;
    fault_undef = accept && (st_q == ST_UNDEF);
    fault_prot  = accept && (st_q == ST_LOOK) && !perm_ok;
    grant       = accept && (st_q == ST_LOOK) && perm_ok;
    rd_en       = (st_q == ST_LOOK) && req_valid && !hit;
    ins_en      = (st_q == ST_WAIT) && rsp_valid && rsp_defined;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOOK:  if (rd_en) st_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) st_d = rsp_defined ? ST_LOOK : ST_UNDEF;
      ST_UNDEF: if (req_valid) st_d = ST_LOOK;
      default:  st_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_LOOK;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/vm_xlate.sv
module vm_xlate #(
  parameter int VA_W    = 12,
  parameter int PA_W    = 12,
  parameter int OFS_W   = 4,
  parameter int ENTRIES = 4,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int FRM_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             xl_valid,
  output logic [PA_W-1:0]  xl_paddr,
  output logic             xl_fault_undef,
  output logic             xl_fault_prot,
  output logic             pt_rd_en,
  output logic [VPN_W-1:0] pt_rd_vpn,
  input  logic             pt_rsp_valid,
  input  logic             pt_rsp_defined,
  input  logic [FRM_W-1:0] pt_rsp_frame,
  input  logic [1:0]       pt_rsp_prot
);
  import vm_xlate_pkg::*;

  logic [VPN_W-1:0]  vpn;
  logic [OFS_W-1:0]  ofs;
  logic              hit, has_free, perm_ok, grant, ins_en;
  logic [IDX_W-1:0]  hit_idx, free_idx, oldest_idx, victim_idx, use_idx;
  logic [FRM_W-1:0]  hit_frame;
  logic [PERM_W-1:0] hit_perm;

  assign vpn = req_vaddr[VA_W-1:OFS_W];
  assign ofs = req_vaddr[OFS_W-1:0];

  vm_xlate_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .FRM_W(FRM_W)) cam_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_vpn(vpn), .hit(hit), .hit_idx(hit_idx),
    .hit_frame(hit_frame), .hit_perm(hit_perm),
    .has_free(has_free), .free_idx(free_idx),
    .ins_en(ins_en), .ins_idx(victim_idx), .ins_vpn(vpn),
    .ins_frame(pt_rsp_frame), .ins_perm(pt_rsp_prot)
  );

  assign victim_idx = has_free ? free_idx : oldest_idx;
  assign use_idx    = ins_en ? victim_idx : hit_idx;

  vm_xlate_lru #(.ENTRIES(ENTRIES)) lru_i (
    .clk(clk), .rst_n(rst_n),
    .use_en(ins_en || (xl_valid && !xl_fault_undef)),
    .use_idx(use_idx), .oldest_idx(oldest_idx)
  );

  assign perm_ok = req_write ? hit_perm[PERM_WR] : hit_perm[PERM_RD];

  vm_xlate_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .hit(hit), .perm_ok(perm_ok),
    .rsp_valid(pt_rsp_valid), .rsp_defined(pt_rsp_defined),
    .ready(req_ready), .accept(xl_valid), .grant(grant),
    .fault_undef(xl_fault_undef), .fault_prot(xl_fault_prot),
    .rd_en(pt_rd_en), .ins_en(ins_en)
  );

  assign pt_rd_vpn = vpn;
  assign xl_paddr  = grant ? {hit_frame, ofs} : '0;
endmodule

// File: rtl/vm_xlate_chk.sv
module vm_xlate_chk #(
  parameter int VA_W  = 12,
  parameter int PA_W  = 12,
  parameter int OFS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            xl_valid,
  input logic [PA_W-1:0] xl_paddr,
  input logic            xl_fault_undef,
  input logic            xl_fault_prot,
  input logic            pt_rd_en
);
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_fault_undef && !xl_fault_prot)
      |-> xl_paddr[OFS_W-1:0] == req_vaddr[OFS_W-1:0]);

  assert_miss_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |-> (req_valid && !req_ready));

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |=> (!pt_rd_en && !req_ready));

  assert_undef_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault_undef |-> (xl_valid && xl_paddr == '0));

  assert_prot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault_prot |-> (xl_valid && xl_paddr == '0));

  assert_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xl_fault_undef, xl_fault_prot}));

  assert_valid_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> req_valid);
endmodule

bind vm_xlate vm_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .xl_valid(xl_valid), .xl_paddr(xl_paddr),
  .xl_fault_undef(xl_fault_undef), .xl_fault_prot(xl_fault_prot),
  .pt_rd_en(pt_rd_en)
);

// File: tb/vm_xlate_tb.sv
module vm_xlate_tb_top;
  localparam int VA_W = 12, PA_W = 12, OFS_W = 4, ENTRIES = 4;
  localparam int VPN_W = VA_W - OFS_W, FRM_W = PA_W - OFS_W;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_ready, xl_valid, xl_fault_undef, xl_fault_prot, pt_rd_en;
  logic [PA_W-1:0] xl_paddr;
  logic [VPN_W-1:0] pt_rd_vpn;
  logic pt_rsp_valid = 1'b0, pt_rsp_defined = 1'b0;
  logic [FRM_W-1:0] pt_rsp_frame = '0;
  logic [1:0] pt_rsp_prot = '0;

  int checks = 0, fails = 0, cyc = 0, reads = 0, rsp_cyc = 0;
  int last_rd_vpn = 0;
  int lru_q [ENTRIES];
  int lru_n = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vm_xlate #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(ENTRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .xl_valid(xl_valid), .xl_paddr(xl_paddr),
    .xl_fault_undef(xl_fault_undef), .xl_fault_prot(xl_fault_prot),
    .pt_rd_en(pt_rd_en), .pt_rd_vpn(pt_rd_vpn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_defined(pt_rsp_defined),
    .pt_rsp_frame(pt_rsp_frame), .pt_rsp_prot(pt_rsp_prot)
  );

  function automatic bit tbl_def(int v);  return (v % 5) != 3; endfunction
  function automatic int tbl_frm(int v);  return (v * 7 + 3) % 256; endfunction
  function automatic int tbl_prm(int v);  return ((v & 3) ^ ((v >> 2) & 3)); endfunction

  function automatic int model_find(int v);
    for (int i = 0; i < lru_n; i++) if (lru_q[i] == v) return i;
    return -1;
  endfunction

  task automatic model_front(int pos, int v);
    for (int i = pos; i > 0; i--) lru_q[i] = lru_q[i-1];
    lru_q[0] = v;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Table responder: answers two cycles after a read pulse.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (pt_rd_en) begin
        reads++;
        last_rd_vpn = int'(pt_rd_vpn);
        @(negedge clk); @(negedge clk);
        pt_rsp_valid   = 1'b1;
        pt_rsp_defined = tbl_def(last_rd_vpn);
        pt_rsp_frame   = FRM_W'(tbl_frm(last_rd_vpn));
        pt_rsp_prot    = 2'(tbl_prm(last_rd_vpn));
        rsp_cyc = cyc;
        @(negedge clk);
        pt_rsp_valid = 1'b0;
      end
    end
  end

  task automatic xlate(int vpn, int ofs, bit wr);
    int pos, rd0, n, exp_pa;
    bit exp_hit, first_rdy, done, d_undef, d_prot, perm;
    logic [PA_W-1:0] pa;
    int done_cyc;
    pos = model_find(vpn);
    exp_hit = (pos >= 0);
    perm = wr ? tbl_prm(vpn)[1] : tbl_prm(vpn)[0];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_vaddr = VA_W'((vpn << OFS_W) | ofs);
    rd0 = reads; n = 0; done = 1'b0; first_rdy = 1'b0; done_cyc = 0;
    d_undef = 1'b0; d_prot = 1'b0; pa = '0;
    while (!done && n < 40) begin
      #3;
      if (n == 0) first_rdy = req_ready;
      if (xl_valid) begin
        done = 1'b1; done_cyc = cyc; pa = xl_paddr;
        d_undef = xl_fault_undef; d_prot = xl_fault_prot;
      end
      n++;
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(done, "R3 completion", int'(done), 1);
    if (exp_hit) begin
      check(first_rdy == 1'b1, "R2 hit ready", int'(first_rdy), 1);
      check(reads == rd0, "R2 hit no read", reads - rd0, 0);
    end else begin
      check(first_rdy == 1'b0, "R3 miss stall", int'(first_rdy), 0);
      check(reads == rd0 + 1, "R3 one read", reads - rd0, 1);
      check(last_rd_vpn == vpn, "R3 read vpn", last_rd_vpn, vpn);
      check(done_cyc == rsp_cyc + 1, "R3 retry cycle", done_cyc, rsp_cyc + 1);
    end
    if (!exp_hit && !tbl_def(vpn)) begin
      check(d_undef && !d_prot && pa == '0, "R5 undefined fault", int'(pa), 0);
    end else if (!perm) begin
      check(d_prot && !d_undef && pa == '0, "R6 protection fault", int'(pa), 0);
    end else begin
      exp_pa = (tbl_frm(vpn) << OFS_W) | ofs;
      check(!d_undef && !d_prot && int'(pa) == exp_pa, "R1 address", int'(pa), exp_pa);
    end
    // Recency model (R7): hits and installs become most recent.
    if (exp_hit) model_front(pos, vpn);
    else if (tbl_def(vpn)) begin
      if (lru_n < ENTRIES) lru_n++;
      model_front(lru_n - 1, vpn);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    lru_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    check(!xl_valid && !pt_rd_en, "R9 reset idle", int'(xl_valid), 0);
    check(!xl_fault_undef && !xl_fault_prot, "R9 reset faults", int'(xl_fault_prot), 0);

    // R4: refill then revisit hits.
    xlate(1, 5, 1'b0);
    xlate(1, 6, 1'b0);
    // R7: fill, refresh page 1, evict page 2 on the next refill.
    xlate(2, 0, 1'b0); xlate(4, 1, 1'b0); xlate(5, 2, 1'b1);
    xlate(1, 3, 1'b1); xlate(6, 4, 1'b0);
    xlate(2, 7, 1'b0); xlate(1, 8, 1'b0); xlate(5, 9, 1'b0);
    // R5: undefined page twice.
    xlate(3, 1, 1'b0); xlate(3, 1, 1'b0);

    // R8: flush then revisit a buffered page.
    xlate(9, 2, 1'b0);
    do_flush();
    xlate(9, 2, 1'b0);

    // Sweep every page with both access types (R1, R6).
    for (int v = 0; v < 256; v++)
      for (int w = 0; w < 2; w++) xlate(v, (v * 5 + w) % 16, w[0]);

    // Small working set: heavy reuse and replacement (R7).
    for (int i = 0; i < 300; i++) xlate((i * i * 3 + i) % 9, i % 16, i[2]);

    do_flush();
    for (int i = 0; i < 40; i++) xlate(i % 6, i % 16, i[0]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule